// File: doc/BRIEF.md
# Linked-List Recency Tracker

This block keeps an exact least-to-most-recently-used order for the ways of one cache set. The order lives in a doubly linked list in registers. Each way holds a forward link and a backward link. Two pointer registers name the most recently used end and the least recently used end.

When an access arrives, the touched way is unlinked from its place and relinked at the most-recent end, all within one clock edge. A cache controller reads the least-recent end to choose a victim. It reads the most-recent end to learn which way was touched last.

The accessed-way input is as wide as the way count needs. When the way count is not a power of two, index values at or above the way count are ignored.

Top module: `lru_chain_tracker`

## Requirements
- R1: While reset (active-low `rst_n`) is held and after it is released, the order is 0,1,…,WAYS−1. `mru_way` reads 0 and `lru_way` reads WAYS−1.
- R2: A valid access to way w with w < WAYS makes `mru_way` equal w after the next rising clock edge.
- R3: After such an access, the way that was most recent before it becomes the second entry in the order.
- R4: When a way in the middle of the order is accessed, its former neighbours become adjacent. The relative order of all other ways is unchanged.
- R5: An access to the way that is already most recent leaves the whole order unchanged.
- R6: An access to the least recent way makes that way's former predecessor the new `lru_way`.
- R7: In a cycle without `touch_vld`, the order is unchanged.
- R8: An access whose index is WAYS or greater leaves the order unchanged.
- R9: Accesses on consecutive clock cycles are each applied in full, one per edge, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_vld | input | 1 | An access to `touch_way` occurs this cycle |
| touch_way | input | IDX_W | Index of the accessed way |
| mru_way | output | IDX_W | Most recently used way (list head) |
| lru_way | output | IDX_W | Least recently used way (list tail) |

## Verification
The hard cycle is an access to the least recent way. In that cycle one access both moves the tail pointer back to the predecessor and moves the head pointer to the accessed way. The same happens, with two links rewritten on a single node, when the way just behind the head is touched.

The bench provokes these cycles by sweeping every ordered pair of indices from a known order, including out-of-range indices. It then drains the list by repeatedly touching the reported LRU way. Each reported LRU value is compared against an arithmetic array model of the order, so any broken link surfaces as a wrong way in the drain sequence.

// File: rtl/lru_chain_tracker.sv
module lru_chain_tracker #(
  parameter int WAYS = 4,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_vld,
  input  logic [IDX_W-1:0] touch_way,
  output logic [IDX_W-1:0] mru_way,
  output logic [IDX_W-1:0] lru_way
);

  logic [IDX_W-1:0] nxt_q [WAYS];
  logic [IDX_W-1:0] prv_q [WAYS];
  logic [IDX_W-1:0] head_q, tail_q;
  logic             in_range, move, at_tail;
  logic [IDX_W-1:0] cur, pred, succ;

  generate
    if ((1 << IDX_W) == WAYS) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = touch_way < IDX_W'(WAYS);
    end
  endgenerate

  assign cur     = touch_way;
  assign pred    = prv_q[cur];
  assign succ    = nxt_q[cur];
  assign at_tail = (cur == tail_q);
  assign move    = touch_vld && in_range && (cur != head_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) begin
        nxt_q[i] <= IDX_W'((i + 1) % WAYS);
        prv_q[i] <= IDX_W'((i + WAYS - 1) % WAYS);
      end
      head_q <= '0;
      tail_q <= IDX_W'(WAYS - 1);
    end else if (move) begin
      if (at_tail) begin
        tail_q <= pred;
      end else begin
        nxt_q[pred] <= succ;
        prv_q[succ] <= pred;
      end
      nxt_q[cur]    <= head_q;
      prv_q[head_q] <= cur;
      head_q        <= cur;
    end
  end

  assign mru_way = head_q;
  assign lru_way = tail_q;

  p_new_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_vld && in_range) |=> (mru_way == $past(touch_way)));

  p_old_head_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> (nxt_q[mru_way] == $past(head_q)));

  p_splice_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (move && !at_tail) |=> (nxt_q[$past(pred)] == $past(succ)));

  p_head_touch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_vld && in_range && cur == head_q) |=> ($stable(mru_way) && $stable(lru_way)));

  p_tail_to_pred_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (move && at_tail) |=> (lru_way == $past(pred)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_vld |=> ($stable(mru_way) && $stable(lru_way)));

  p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_vld && !in_range) |=> ($stable(mru_way) && $stable(lru_way)));

  p_ends_differ_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (WAYS > 1) |-> (mru_way != lru_way));

endmodule

// File: tb/test_lru_chain_tracker.sv
module test_lru_chain_tracker;
  localparam int WAYS  = 5;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             touch_vld = 1'b0;
  logic [IDX_W-1:0] touch_way = '0;
  logic [IDX_W-1:0] mru_way, lru_way;

  int ord [WAYS];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lru_chain_tracker #(.WAYS(WAYS)) i_lru_chain_tracker (
    .clk(clk), .rst_n(rst_n), .touch_vld(touch_vld), .touch_way(touch_way),
    .mru_way(mru_way), .lru_way(lru_way)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model(input bit v, input int w);
    int pos;
    if (!v || w >= WAYS) return;
    pos = 0;
    for (int k = 0; k < WAYS; k++) if (ord[k] == w) pos = k;
    for (int k = pos; k > 0; k--) ord[k] = ord[k-1];
    ord[0] = w;
  endfunction

  task automatic step(input bit v, input int w);
    string tag;
    if (!v) tag = "R7";
    else if (w >= WAYS) tag = "R8";
    else if (w == ord[0]) tag = "R5";
    else if (w == ord[WAYS-1]) tag = "R6";
    else tag = "R4";
    touch_vld = v;
    touch_way = IDX_W'(w);
    @(posedge clk); #2;
    model(v, w);
    check({tag, " mru"}, int'(mru_way), ord[0]);
    check({tag, " lru"}, int'(lru_way), ord[WAYS-1]);
    if (v && w < WAYS) check("R2 R9", int'(mru_way), w);
  endtask

  task automatic drain();
    for (int k = 0; k < WAYS; k++) begin
      check("R3 R4 order", int'(lru_way), ord[WAYS-1]);
      step(1'b1, ord[WAYS-1]);
    end
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    for (int k = 0; k < WAYS; k++) ord[k] = k;
    repeat (3) @(posedge clk);
    #2;
    check("R1 mru in reset", int'(mru_way), 0);
    check("R1 lru in reset", int'(lru_way), WAYS-1);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 mru", int'(mru_way), 0);
    check("R1 lru", int'(lru_way), WAYS-1);

    for (int a = 0; a < (1 << IDX_W); a++)
      for (int b = 0; b < (1 << IDX_W); b++) begin
        step(1'b1, a);
        step(1'b0, b);
        step(1'b1, b);
        step(1'b1, a);
        drain();
      end

    seed = 7;
    for (int k = 0; k < 3000; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step(((seed >> 20) & 7) != 0, (seed >> 8) & ((1 << IDX_W) - 1));
    end
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule